// File: doc/BRIEF.md
# Word-Serial Packet Handoff Bridge

This block carries packets one 32-bit word at a time from a physical-layer-side source to a link-layer-side sink. The source posts a request made of a two-bit priority code and a 32-bit descriptor. The bridge then asks for each packet word with a one-cycle fetch pulse and passes each returned word on to the sink together with a strobe. A busy flag stays high for the whole transfer so that no other upward packet starts while one is in flight.

The next word is always fetched while the current one is still on its way, so the strobes of one packet come in consecutive cycles. An urgent request cuts the active transfer short and restarts the bridge on the new packet. A normal request that comes in while the bridge is busy is parked in a single holding slot and starts once the bridge has gone idle.

Top module: `pkt_handoff_bridge`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy_o`, `fetch_o` and `link_stb_o` are all low.
- R2: `req_pri_i` uses three codes: 2'b00 means no request, 2'b10 is a normal request and 2'b01 is an urgent request. In the descriptor, bits 31:16 hold a length value L and the packet is L+1 words long. Bits 15:0 hold request data, which appears unchanged on `active_desc_o`.
- R3: When the bridge is idle and has no held request, a request present at a clock edge is accepted at that edge. From the cycle that edge starts (the acceptance cycle), `busy_o` is high and `active_desc_o` equals the posted descriptor.
- R4: A packet of length value L produces exactly L+1 one-cycle pulses on `fetch_o`. The pulses fall in consecutive cycles, and the first one falls in the acceptance cycle.
- R5: The source drives the requested word on `src_word_i` in the cycle after a fetch pulse. The bridge shows that word on `link_word_o`, with `link_stb_o` high, one cycle later. The strobes of a packet come in consecutive cycles and carry the words in the order they were fetched.
- R6: `busy_o` goes low in the cycle after the cycle of the last strobe. That cycle is L+3 cycles after the acceptance cycle.
- R7: An urgent request is accepted at the next edge in any state. No word of the interrupted packet is strobed after that edge, words already fetched for it are discarded, and no error indication is given. The new packet's descriptor is latched and its fetches start in the acceptance cycle.
- R8: A normal request that arrives while the bridge is busy is held. It is accepted at the edge that ends the first idle cycle, so `busy_o` is low for exactly one cycle between the two packets.
- R9: A normal request that arrives while the holding slot is already occupied is ignored. It never produces a fetch, a strobe or a change of `active_desc_o`.
- R10: The code 2'b11 on `req_pri_i` is ignored.
- R11: The largest length value, 16'hFFFF, moves 65536 words as one unbroken run of strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_pri_i | input | 2 | Request priority code |
| req_desc_i | input | 32 | Request descriptor (length in 31:16, request data in 15:0) |
| src_word_i | input | 32 | Packet word from the source, valid in the cycle after a fetch pulse |
| fetch_o | output | 1 | One-cycle request for the next source word |
| link_word_o | output | 32 | Word passed to the link side |
| link_stb_o | output | 1 | Arrival strobe for `link_word_o` |
| active_desc_o | output | 32 | Descriptor of the packet now being moved |
| busy_o | output | 1 | High while a packet is in flight |

## Verification
The assertions assume that the source answers every fetch pulse with a word in the next cycle and never holds a word back. They also assume that a request code is present for exactly one cycle per posting. The stimulus keeps to both rules: its source model answers each sampled fetch at the following edge, and every request is driven for one cycle and then returned to 2'b00. Expected cycles and word values come from the acceptance cycle and from a running count of fetches made to the source model.

// File: rtl/phb_pkg.sv
package phb_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 16;
    localparam int INFO_W = 16;
    localparam int DESC_W = LEN_W + INFO_W;

    // request priority codes; values are fixed by the requester
    typedef enum logic [1:0] {
        PRI_NONE   = 2'b00,
        PRI_URGENT = 2'b01,
        PRI_NORMAL = 2'b10,
        PRI_RSVD   = 2'b11
    } pri_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_DRAIN = 2'd2
    } xfer_st_e;

    // length sits in the upper half, request data in the lower half
    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [INFO_W-1:0] info;
    } desc_t;

    function automatic logic pri_is_urgent(input logic [1:0] p);
        return p == PRI_URGENT;
    endfunction

    function automatic logic pri_is_normal(input logic [1:0] p);
        return p == PRI_NORMAL;
    endfunction

endpackage

// File: rtl/phb_pend_slot.sv
module phb_pend_slot
    import phb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  logic  take_i,
    input  desc_t desc_i,
    output logic  vld_o,
    output desc_t desc_o
);

    logic  vld_q;
    desc_t desc_q;

    // a new entry is taken only when the slot is free or being emptied
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            desc_q <= '0;
        end else if (load_i && (!vld_q || take_i)) begin
            vld_q  <= 1'b1;
            desc_q <= desc_i;
        end else if (take_i) begin
            vld_q  <= 1'b0;
        end
    end

    assign vld_o  = vld_q;
    assign desc_o = desc_q;

    AST_PEND_KEEP: assert property (@(posedge clk) disable iff (rst) (vld_q && !take_i) |=> (vld_q && $stable(desc_q))) else $error("held request lost or changed"); // R9

endmodule

// File: rtl/phb_fetch_ctl.sv
module phb_fetch_ctl
    import phb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    input  logic             run_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             fetch_o,
    output logic             inflight_o
);

    logic [LEN_W-1:0] fcnt_q;
    logic             fdone_q;
    logic             inflight_q;

    // fetch runs one word ahead of the output stage
    assign fetch_o = run_i && !fdone_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fcnt_q     <= '0;
            fdone_q    <= 1'b0;
            inflight_q <= 1'b0;
        end else if (restart_i) begin
            fcnt_q     <= '0;
            fdone_q    <= 1'b0;
            inflight_q <= 1'b0;
        end else begin
            inflight_q <= fetch_o;
            if (fetch_o) begin
                if (fcnt_q == len_i) fdone_q <= 1'b1;
                else                 fcnt_q  <= fcnt_q + 1'b1;
            end
        end
    end

    assign inflight_o = inflight_q;

    AST_FETCH_STOPS: assert property (@(posedge clk) disable iff (rst) (fdone_q && !restart_i) |=> !fetch_o) else $error("fetch beyond packet end"); // R4

endmodule

// File: rtl/phb_out_stage.sv
module phb_out_stage
    import phb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart_i,
    input  logic              word_vld_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              stb_o,
    output logic [WORD_W-1:0] word_o,
    output logic              last_cap_o
);

    logic [LEN_W-1:0]  wcnt_q;
    logic              stb_q;
    logic [WORD_W-1:0] word_q;

    assign last_cap_o = word_vld_i && !restart_i && (wcnt_q == len_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt_q <= '0;
            stb_q  <= 1'b0;
            word_q <= '0;
        end else if (restart_i) begin
            wcnt_q <= '0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= word_vld_i;
            if (word_vld_i) begin
                word_q <= word_i;
                wcnt_q <= wcnt_q + 1'b1;
            end
        end
    end

    assign stb_o  = stb_q;
    assign word_o = word_q;

    AST_STB_FOLLOWS_WORD: assert property (@(posedge clk) disable iff (rst) stb_q |-> $past(word_vld_i && !restart_i)) else $error("strobe without captured word"); // R5

endmodule

// File: rtl/pkt_handoff_bridge.sv
module pkt_handoff_bridge
    import phb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        req_pri_i,
    input  logic [DESC_W-1:0] req_desc_i,
    input  logic [WORD_W-1:0] src_word_i,
    output logic              fetch_o,
    output logic [WORD_W-1:0] link_word_o,
    output logic              link_stb_o,
    output logic [DESC_W-1:0] active_desc_o,
    output logic              busy_o
);

    xfer_st_e state_q;
    desc_t    cur_q;
    desc_t    req_desc;
    desc_t    pend_desc;
    desc_t    sel_desc;
    logic     pend_vld;
    logic     is_urg;
    logic     is_norm;
    logic     idle;
    logic     pend_take;
    logic     start_norm;
    logic     pend_load;
    logic     restart;
    logic     inflight;
    logic     last_cap;

    assign req_desc   = desc_t'(req_desc_i);
    assign is_urg     = pri_is_urgent(req_pri_i);
    assign is_norm    = pri_is_normal(req_pri_i);
    assign idle       = (state_q == ST_IDLE);

    // a held request goes first once idle; urgent always wins
    assign pend_take  = idle && pend_vld && !is_urg;
    assign start_norm = idle && !pend_vld && is_norm;
    assign pend_load  = is_norm && !start_norm;
    assign restart    = is_urg || pend_take || start_norm;
    assign sel_desc   = pend_take ? pend_desc : req_desc;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else if (restart) begin
            state_q <= ST_XFER;
            cur_q   <= sel_desc;
        end else begin
            case (state_q)
                ST_XFER:  if (last_cap) state_q <= ST_DRAIN;
                ST_DRAIN: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    phb_pend_slot pend_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (pend_load),
        .take_i (pend_take),
        .desc_i (req_desc),
        .vld_o  (pend_vld),
        .desc_o (pend_desc)
    );

    phb_fetch_ctl fetch_i (
        .clk        (clk),
        .rst        (rst),
        .restart_i  (restart),
        .run_i      (state_q == ST_XFER),
        .len_i      (cur_q.len),
        .fetch_o    (fetch_o),
        .inflight_o (inflight)
    );

    phb_out_stage out_i (
        .clk        (clk),
        .rst        (rst),
        .restart_i  (restart),
        .word_vld_i (inflight),
        .word_i     (src_word_i),
        .len_i      (cur_q.len),
        .stb_o      (link_stb_o),
        .word_o     (link_word_o),
        .last_cap_o (last_cap)
    );

    assign busy_o        = !idle;
    assign active_desc_o = cur_q;

    AST_FETCH_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst) fetch_o |-> busy_o) else $error("fetch while idle"); // R4
    AST_STB_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst) link_stb_o |-> busy_o) else $error("strobe while idle"); // R5
    AST_URGENT_CUTS: assert property (@(posedge clk) disable iff (rst) is_urg |=> (busy_o && fetch_o && !link_stb_o)) else $error("urgent did not restart"); // R7
    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (rst) (idle && !pend_vld && req_pri_i == PRI_RSVD) |=> !busy_o) else $error("reserved code started a packet"); // R10
    AST_DRAIN_RELEASE: assert property (@(posedge clk) disable iff (rst) (state_q == ST_DRAIN && !is_urg) |=> !busy_o) else $error("busy held after last word"); // R6

endmodule

// File: tb/pkt_handoff_bridge_tb.sv
module pkt_handoff_bridge_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 150000;
    localparam logic [31:0] TAG = 32'hC000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  req_pri = 2'b00;
    logic [31:0] req_desc = '0;
    logic [31:0] src_word = '0;
    logic        fetch_o, link_stb_o, busy_o;
    logic [31:0] link_word_o, active_desc_o;

    int cyc = 0;
    int gcnt = 0;
    int checks = 0;
    int fails = 0;
    logic fetch_seen = 1'b0;

    int n_rec = 0, nf = 0, brk = 0;
    int rec_w [64];
    int rec_c [64];
    logic have_prev = 1'b0;
    logic [31:0] prev_w = '0;
    int prev_c = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_handoff_bridge dut_i (
        .clk           (clk),
        .rst           (rst),
        .req_pri_i     (req_pri),
        .req_desc_i    (req_desc),
        .src_word_i    (src_word),
        .fetch_o       (fetch_o),
        .link_word_o   (link_word_o),
        .link_stb_o    (link_stb_o),
        .active_desc_o (active_desc_o),
        .busy_o        (busy_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // source model: answers a fetch in the following cycle
    always @(negedge clk) fetch_seen <= fetch_o;
    always @(posedge clk) begin
        #1;
        if (fetch_seen) begin
            src_word = TAG | 32'(gcnt);
            gcnt = gcnt + 1;
        end
    end

    // sink monitor
    always @(negedge clk) begin
        if (fetch_o) nf = nf + 1;
        if (link_stb_o) begin
            if (n_rec < 64) begin
                rec_w[n_rec] = int'(link_word_o);
                rec_c[n_rec] = cyc;
            end
            if (have_prev && (link_word_o != prev_w + 1 || cyc != prev_c + 1)) brk = brk + 1;
            have_prev = 1'b1;
            prev_w = link_word_o;
            prev_c = cyc;
            n_rec = n_rec + 1;
        end
    end

    always @(posedge clk) begin
        if (cyc > WDOG_LIMIT) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: cycles=%0d limit=%0d", cyc, WDOG_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk);
        #1;
        n_rec = 0; nf = 0; brk = 0; have_prev = 1'b0;
        @(negedge clk);
    endtask

    // called at a negedge; returns at the negedge of the acceptance cycle
    task automatic post(input logic [1:0] p, input logic [31:0] d);
        req_pri = p;
        req_desc = d;
        @(negedge clk);
        req_pri = 2'b00;
    endtask

    task automatic wait_idle(output int lowc);
        while (busy_o) @(negedge clk);
        lowc = cyc;
    endtask

    initial begin
        int a, g0, lowc, lowc2, mism, na, fa;
        logic [31:0] d, db, dc;

        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", busy_o, 0);
        chk("R1 fetch", fetch_o, 0);
        chk("R1 strobe", link_stb_o, 0);

        // normal packets over a sweep of lengths
        for (int len = 0; len < 8; len++) begin
            clear_mon();
            d = {16'(len), 16'h5A00 + 16'(len)};
            post(2'b10, d);
            a = cyc; g0 = gcnt;
            chk("R3 busy at accept", busy_o, 1);
            chk("R2 R3 descriptor", active_desc_o, d);
            chk("R4 first fetch", fetch_o, 1);
            wait_idle(lowc);
            #1;
            chk("R2 R5 word count", n_rec, len + 1);
            chk("R4 fetch count", nf, len + 1);
            mism = 0;
            for (int i = 0; i <= len; i++)
                if (rec_w[i] != int'(TAG | 32'(g0 + i)) || rec_c[i] != a + 2 + i) mism++;
            chk("R5 order and timing", mism, 0);
            chk("R6 busy release", lowc, a + len + 3);
        end

        // urgent preemption at every point of a short packet
        for (int p = 1; p <= 8; p++) begin
            clear_mon();
            d  = {16'd5, 16'h1111};
            db = {16'd2, 16'h2222};
            post(2'b10, d);
            a = cyc; g0 = gcnt;
            repeat (p - 1) @(negedge clk);
            post(2'b01, db);
            chk("R7 new descriptor", active_desc_o, db);
            chk("R7 fetch restarts", fetch_o, 1);
            wait_idle(lowc);
            #1;
            na = (p < 2) ? 0 : ((p - 2 < 6) ? p - 2 : 6);
            fa = (p < 6) ? p : 6;
            chk("R7 strobe count", n_rec, na + 3);
            mism = 0;
            for (int i = 0; i < na; i++)
                if (rec_w[i] != int'(TAG | 32'(g0 + i)) || rec_c[i] != a + 2 + i) mism++;
            for (int j = 0; j < 3; j++)
                if (rec_w[na + j] != int'(TAG | 32'(g0 + fa + j)) || rec_c[na + j] != a + p + 2 + j) mism++;
            chk("R7 words kept and dropped", mism, 0);
            chk("R7 release", lowc, a + p + 5);
        end

        // held request and ignored second request
        clear_mon();
        d  = {16'd3, 16'h3333};
        db = {16'd1, 16'h4444};
        dc = {16'd0, 16'h5555};
        post(2'b10, d);
        a = cyc;
        post(2'b10, db);
        post(2'b10, dc);
        wait_idle(lowc);
        chk("R6 first release", lowc, a + 6);
        @(negedge clk);
        chk("R8 held starts", busy_o, 1);
        chk("R8 held descriptor", active_desc_o, db);
        wait_idle(lowc2);
        chk("R8 held release", lowc2, a + 11);
        repeat (10) @(negedge clk);
        #1;
        chk("R8 held word timing", rec_c[4], a + 9);
        chk("R9 third request ignored", n_rec, 6);
        chk("R9 descriptor unchanged", active_desc_o, db);

        // reserved code
        clear_mon();
        post(2'b11, {16'd2, 16'h6666});
        repeat (5) @(negedge clk);
        #1;
        chk("R10 no busy", busy_o, 0);
        chk("R10 no fetch", nf, 0);
        chk("R10 no strobe", n_rec, 0);

        // urgent while idle
        clear_mon();
        post(2'b01, {16'd0, 16'h7777});
        chk("R2 urgent from idle", busy_o, 1);
        wait_idle(lowc);
        #1;
        chk("R2 urgent one word", n_rec, 1);

        // longest packet
        clear_mon();
        post(2'b10, {16'hFFFF, 16'h0001});
        a = cyc;
        wait_idle(lowc);
        #1;
        chk("R11 word count", n_rec, 65536);
        chk("R11 unbroken run", brk, 0);
        chk("R11 fetch count", nf, 65536);
        chk("R11 release", lowc, a + 65538);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule